// File: doc/BRIEF.md
# Interworking Branch and Program Counter Unit

This block holds the program counter and a single state bit that selects one of two instruction encodings. In the wide encoding every instruction is 4 bytes long. In the compact encoding every instruction is 2 bytes long. On each clock edge the unit takes one of three commands. A sequential step moves the PC to the next instruction. A call branch jumps to a PC-relative target and hands back a link value. An exchange branch jumps to a register-held address and can change the encoding.

The encoding travels in bit 0 of addresses. An exchange branch reads its new encoding from bit 0 of the register target. A call branch records the caller's encoding in bit 0 of the link value. An exchange branch on that link value therefore returns to the caller in the caller's own encoding.

The command, offset and target inputs are plain control pins with no handshake. The unit accepts a command on every rising edge and never stalls, so there is no back-pressure path. All outputs are registered and change on the edge that samples the command.

Top module: `ibx_pc_unit`

## Requirements
- R1: While `rst_n` is low, `pc` equals the parameter `RESET_VEC`, `compact` is 0 (wide) and `link_we` is 0.
- R2: A sequential step (`cmd_step` alone) adds 4 to `pc` when `compact` is 0 and adds 2 when `compact` is 1. The state bit does not change.
- R3: A call branch (`cmd_call` without `cmd_xchg`) loads `pc` with `pc` plus the sign-extended `call_ofs`, scaled by 4 in the wide state and by 2 in the compact state. The state bit does not change.
- R4: On the edge that takes a call branch, `link_we` rises for exactly one cycle. `link_data` then equals the old `pc` plus the instruction size (4 wide, 2 compact), with bit 0 replaced by the old `compact` value.
- R5: An exchange branch (`cmd_xchg`) sets `compact` to bit 0 of `xchg_tgt`: a 1 selects compact and a 0 selects wide.
- R6: An exchange branch never uses `xchg_tgt[0]` as an address bit. When the new state is compact, `pc` = `xchg_tgt` with bit 0 cleared. When the new state is wide, `pc` = `xchg_tgt` with bits 1 and 0 cleared.
- R7: An exchange branch whose bit 0 matches the current state leaves `compact` unchanged and acts as a plain register branch.
- R8: When several commands are asserted together, exchange wins over call, and call wins over step. A call that loses to an exchange does not raise `link_we`.
- R9: With no command asserted, `pc` and `compact` hold their values and `link_we` stays 0.
- R10: An exchange branch on a value that an earlier call placed on `link_data` returns `pc` to the instruction after that call and restores the caller's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_step | input | 1 | Sequential step command |
| cmd_call | input | 1 | Call branch (branch with link) command |
| cmd_xchg | input | 1 | Exchange branch command |
| call_ofs | input | OFS_W | Signed call offset, in instruction units |
| xchg_tgt | input | AW | Register target for an exchange branch; bit 0 is the new state |
| pc | output | AW | Current program counter |
| compact | output | 1 | Current state: 1 compact (2-byte), 0 wide (4-byte) |
| link_we | output | 1 | One-cycle strobe telling the register file to write the link value |
| link_data | output | AW | Link value: return address with the caller's state in bit 0 |

## Verification
The assertions check on every cycle that:
- a step advances the PC by the size that matches the state;
- an exchange copies target bit 0 into the state;
- the PC stays even, and stays word-aligned in the wide state;
- `link_we` follows exactly the call commands that win arbitration, with the caller's state in bit 0 of the link value;
- an idle cycle holds everything.

The bench's scenarios show the parts that need the arithmetic done out:
- call targets with negative and positive offsets in both states;
- clearing of the ignored low bits;
- the full call-and-return round trip that restores the caller's state;
- combined commands resolved by priority.

// File: rtl/ibx_pkg.sv
package ibx_pkg;

  // Operation chosen for the current cycle after priority resolution
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_CALL = 2'd2,
    OP_XCHG = 2'd3
  } op_e;

  // Instruction sizes in bytes for each state
  localparam int unsigned WIDE_BYTES    = 4;
  localparam int unsigned COMPACT_BYTES = 2;

endpackage

// File: rtl/ibx_cmd_arb.sv
module ibx_cmd_arb
  import ibx_pkg::*;
(
  input  logic cmd_step,
  input  logic cmd_call,
  input  logic cmd_xchg,
  output op_e  op
);

  // Exchange over call, call over step, otherwise hold
  always_comb begin
    if (cmd_xchg)      op = OP_XCHG;
    else if (cmd_call) op = OP_CALL;
    else if (cmd_step) op = OP_STEP;
    else               op = OP_HOLD;
  end

endmodule

// File: rtl/ibx_target_calc.sv
module ibx_target_calc
  import ibx_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFS_W = 24
) (
  input  logic [AW-1:0]    pc,
  input  logic             compact,
  input  logic [OFS_W-1:0] call_ofs,
  input  logic [AW-1:0]    xchg_tgt,
  output logic [AW-1:0]    seq_pc,
  output logic [AW-1:0]    call_pc,
  output logic [AW-1:0]    xchg_pc,
  output logic             xchg_compact
);

  localparam int unsigned EXT_W = AW - OFS_W;

  logic [AW-1:0] ins_size;
  logic [AW-1:0] ofs_ext;
  logic [AW-1:0] ofs_scaled;

  assign ins_size = compact ? AW'(COMPACT_BYTES) : AW'(WIDE_BYTES);

  // Sign extension of the offset; a parameter picks the form
  generate
    if (EXT_W > 0) begin : g_ext
      assign ofs_ext = {{EXT_W{call_ofs[OFS_W-1]}}, call_ofs};
    end else begin : g_noext
      assign ofs_ext = call_ofs[AW-1:0];
    end
  endgenerate

  // Offset counts instructions, so scale by the current size
  assign ofs_scaled = compact ? (ofs_ext << 1) : (ofs_ext << 2);

  assign seq_pc  = pc + ins_size;
  assign call_pc = pc + ofs_scaled;

  // Bit 0 carries the state; bit 1 is an address bit only in compact
  assign xchg_compact = xchg_tgt[0];
  assign xchg_pc      = {xchg_tgt[AW-1:2], xchg_tgt[0] & xchg_tgt[1], 1'b0};

endmodule

// File: rtl/ibx_link_gen.sv
module ibx_link_gen
  import ibx_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [AW-1:0] seq_pc,
  input  logic          compact,
  output logic          link_we,
  output logic [AW-1:0] link_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_we   <= 1'b0;
      link_data <= '0;
    end else begin
      link_we <= (op == OP_CALL);
      if (op == OP_CALL) begin
        link_data <= {seq_pc[AW-1:1], compact};
      end
    end
  end

endmodule

// File: rtl/ibx_pc_unit.sv
module ibx_pc_unit
  import ibx_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned OFS_W     = 24,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_step,
  input  logic             cmd_call,
  input  logic             cmd_xchg,
  input  logic [OFS_W-1:0] call_ofs,
  input  logic [AW-1:0]    xchg_tgt,
  output logic [AW-1:0]    pc,
  output logic             compact,
  output logic             link_we,
  output logic [AW-1:0]    link_data
);

  op_e           op;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] call_pc;
  logic [AW-1:0] xchg_pc;
  logic          xchg_compact;
  logic [AW-1:0] pc_nxt;
  logic          compact_nxt;

  ibx_cmd_arb u_arb (
    .cmd_step (cmd_step),
    .cmd_call (cmd_call),
    .cmd_xchg (cmd_xchg),
    .op       (op)
  );

  ibx_target_calc #(.AW(AW), .OFS_W(OFS_W)) u_calc (
    .pc           (pc),
    .compact      (compact),
    .call_ofs     (call_ofs),
    .xchg_tgt     (xchg_tgt),
    .seq_pc       (seq_pc),
    .call_pc      (call_pc),
    .xchg_pc      (xchg_pc),
    .xchg_compact (xchg_compact)
  );

  ibx_link_gen #(.AW(AW)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .seq_pc    (seq_pc),
    .compact   (compact),
    .link_we   (link_we),
    .link_data (link_data)
  );

  always_comb begin
    pc_nxt      = pc;
    compact_nxt = compact;
    unique case (op)
      OP_STEP: pc_nxt = seq_pc;
      OP_CALL: pc_nxt = call_pc;
      OP_XCHG: begin
        pc_nxt      = xchg_pc;
        compact_nxt = xchg_compact;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= RESET_VEC[AW-1:0];
      compact <= 1'b0;
    end else begin
      pc      <= pc_nxt;
      compact <= compact_nxt;
    end
  end

endmodule

// File: rtl/ibx_pc_unit_chk.sv
module ibx_pc_unit_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFS_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_step,
  input logic             cmd_call,
  input logic             cmd_xchg,
  input logic [OFS_W-1:0] call_ofs,
  input logic [AW-1:0]    xchg_tgt,
  input logic [AW-1:0]    pc,
  input logic             compact,
  input logic             link_we,
  input logic [AW-1:0]    link_data
);

  a_r2_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_step && !cmd_call && !cmd_xchg) |=>
      (pc == $past(pc) + ($past(compact) ? AW'(2) : AW'(4))) && (compact == $past(compact)));

  a_r4_link_on_call: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_call && !cmd_xchg) |=> link_we && (link_data[0] == $past(compact)));

  a_r8_no_link_else: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_call && !cmd_xchg) |=> !link_we);

  a_r5_xchg_state: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_xchg |=> (compact == $past(xchg_tgt[0])));

  a_r6_pc_align: assert property (@(posedge clk) disable iff (!rst_n)
    (pc[0] == 1'b0) && (compact || (pc[1] == 1'b0)));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_step && !cmd_call && !cmd_xchg) |=> $stable(pc) && $stable(compact));

endmodule

bind ibx_pc_unit ibx_pc_unit_chk #(.AW(AW), .OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_step  (cmd_step),
  .cmd_call  (cmd_call),
  .cmd_xchg  (cmd_xchg),
  .call_ofs  (call_ofs),
  .xchg_tgt  (xchg_tgt),
  .pc        (pc),
  .compact   (compact),
  .link_we   (link_we),
  .link_data (link_data)
);

// File: tb/sim_ibx_pc_unit.sv
`timescale 1ns/1ps
module sim_ibx_pc_unit;

  localparam int unsigned AW    = 32;
  localparam int unsigned OFS_W = 24;
  localparam logic [31:0] RVEC  = 32'h0000_0100;

  typedef struct {
    logic [31:0] pc;
    logic        cmp;
    logic        we;
    logic [31:0] ld;
    string       tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_step = 1'b0;
  logic             cmd_call = 1'b0;
  logic             cmd_xchg = 1'b0;
  logic [OFS_W-1:0] call_ofs = '0;
  logic [AW-1:0]    xchg_tgt = '0;
  logic [AW-1:0]    pc;
  logic             compact;
  logic             link_we;
  logic [AW-1:0]    link_data;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  exp_t q[$];

  logic [31:0] m_pc  = RVEC;
  logic        m_cmp = 1'b0;
  logic [31:0] saved_link;

  always #10 clk = ~clk;

  ibx_pc_unit #(.AW(AW), .OFS_W(OFS_W), .RESET_VEC(RVEC)) u0 (
    .clk (clk), .rst_n (rst_n), .cmd_step (cmd_step), .cmd_call (cmd_call),
    .cmd_xchg (cmd_xchg), .call_ofs (call_ofs), .xchg_tgt (xchg_tgt),
    .pc (pc), .compact (compact), .link_we (link_we), .link_data (link_data)
  );

  // Driver: applies one command at a falling edge and records the expected result
  task automatic issue(input bit s, input bit c, input bit x,
                       input int ofs, input logic [31:0] tgt, input string tag);
    exp_t e;
    logic [31:0] sz;
    logic [31:0] nx_pc;
    logic        nx_cmp;
    cmd_step = s; cmd_call = c; cmd_xchg = x;
    call_ofs = OFS_W'(ofs); xchg_tgt = tgt;
    sz = m_cmp ? 32'd2 : 32'd4;
    nx_pc = m_pc; nx_cmp = m_cmp;
    e.we = 1'b0; e.ld = '0;
    if (x) begin
      nx_cmp = tgt[0];
      nx_pc  = tgt[0] ? (tgt & ~32'h1) : (tgt & ~32'h3);
    end else if (c) begin
      nx_pc = m_pc + 32'(ofs) * sz;
      e.we  = 1'b1;
      e.ld  = ((m_pc + sz) & ~32'h1) | {31'd0, m_cmp};
    end else if (s) begin
      nx_pc = m_pc + sz;
    end
    m_pc = nx_pc; m_cmp = nx_cmp;
    e.pc = nx_pc; e.cmp = nx_cmp; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    cmd_step = 1'b0; cmd_call = 1'b0; cmd_xchg = 1'b0;
  endtask

  // Monitor: compares after each rising edge, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (pc !== e.pc || compact !== e.cmp || link_we !== e.we ||
            (e.we && link_data !== e.ld)) begin
          n_fail++;
          $display("FAIL %s: pc=%h cmp=%b we=%b ld=%h expected pc=%h cmp=%b we=%b ld=%h",
                   e.tag, pc, compact, link_we, link_data, e.pc, e.cmp, e.we, e.ld);
        end
        if (e.we) saved_link = link_data;
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (pc !== RVEC || compact !== 1'b0 || link_we !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: pc=%h cmp=%b we=%b expected pc=%h cmp=0 we=0", pc, compact, link_we, RVEC);
    end
    rst_n = 1'b1;
    @(negedge clk);

    issue(1, 0, 0, 0, 0, "R2 wide step");
    issue(1, 0, 0, 0, 0, "R2 wide step 2");
    issue(0, 0, 0, 0, 0, "R9 idle hold");
    issue(0, 1, 0, -2, 0, "R3/R4 wide call back");
    issue(0, 0, 0, 0, 0, "R4 strobe drops");
    issue(0, 1, 0, 16, 0, "R3 wide call fwd");
    issue(0, 0, 1, 0, 32'h0000_2003, "R5/R6 xchg to compact");
    issue(1, 0, 0, 0, 0, "R2 compact step");
    issue(0, 0, 1, 0, 32'h0000_2011, "R7 xchg same compact");
    issue(0, 1, 0, 5, 0, "R3/R4 compact call");
    issue(1, 0, 0, 0, 0, "R2 step in callee");
    issue(0, 0, 1, 0, saved_link, "R10 return to compact caller");
    issue(0, 0, 1, 0, 32'h0000_3006, "R5/R6 xchg to wide drops bit1");
    issue(0, 0, 1, 0, 32'h0000_3104, "R7 xchg same wide");
    issue(0, 1, 0, -3, 0, "R4 wide call for return");
    issue(0, 0, 1, 0, 32'h0000_5001, "R5 enter compact callee");
    issue(1, 0, 0, 0, 0, "R2 compact step in callee");
    issue(0, 0, 1, 0, saved_link, "R10 return to wide caller");
    issue(1, 1, 1, 7, 32'h0000_4009, "R8 xchg beats call and step");
    issue(1, 1, 0, 3, 0, "R8 call beats step");
    issue(0, 0, 0, 0, 0, "R9 idle after call");
    issue(0, 0, 0, 0, 0, "R9 idle again");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule